// File: doc/BRIEF.md
# Serial Receiver with Tagged Character Queue

This block receives asynchronous serial characters on one input line. The frame format is set by plain configuration inputs: 5 to 8 data bits, five parity choices, and one or two stop bits. The receiver oversamples the line at 16 ticks per bit. The tick comes from a programmable divisor of the core clock. Every finished character is stored in a 16-entry queue together with its own four error tags, so software can tell exactly which character was damaged. A character is removed from the queue by pulsing the read strobe while its data and tags are shown at the head.

The frame state machine has six states:
- `S_IDLE` waits for a low tick on the line and then moves to `S_START`.
- `S_START` checks the line again at its eighth tick. A high line means a glitch, so the machine returns to `S_IDLE`; a low line moves it to `S_DATA`.
- `S_DATA` samples each data bit at mid-bit. After the last data bit it moves to `S_PARITY` when parity is enabled, and to `S_STOP` otherwise.
- `S_PARITY` samples one bit and then moves to `S_STOP`.
- `S_STOP` samples one or two stop bits and then pushes the character. A clean frame returns to `S_IDLE`. A framing error or a break moves to `S_RECOVER`.
- `S_RECOVER` waits for the line to go high and then returns to `S_IDLE`.

Status outputs give the queue fill, a full flag, a data-ready flag, a sticky "queue holds a damaged entry" flag, and a fill-level interrupt with its own enable.

Top module: `uart_rx_errfifo`

## Requirements
- R1: One bit period lasts 16 x (baud_div_i + 1) clock cycles. Frames are received correctly with divisor 0 and with divisor 2.
- R2: data_len_i selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives LSB first and is presented on rd_data_o right-aligned, with the unused upper bits zero.
- R3: A start bit is accepted only if the line is still low at the eighth tick after the falling edge. A low pulse shorter than that stores nothing.
- R4: parity_i selects the parity mode: codes 0 to 3 mean no parity bit, 4 means odd, 5 means even, 6 means the bit must be 1 and 7 means it must be 0. A mismatch sets rd_err_o[1].
- R5: two_stop_i=0 selects one stop bit and 1 selects two. Any stop bit sampled low sets rd_err_o[2]. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: If the line stays low through the whole frame, including all stop bits, exactly one entry is stored: data 0 with only rd_err_o[3] (break) set.
- R7: The queue holds 16 entries in arrival order. fifo_count_o is 4 bits and reads 0 when the queue is full, and fifo_full_o is then 1.
- R8: A character that completes while the queue is full is discarded, and rd_err_o[0] (overrun) is set on the newest stored entry.
- R9: rx_int_o is 1 exactly when rx_int_en_i is 1 and the fill is at least (trig_lvl_i+1) x 4.
- R10: fifo_err_o is 1 while any stored entry has an error tag. It clears only when the last such entry is read out.
- R11: data_ready_o is 1 whenever the queue is not empty. A read strobe on an empty queue has no effect.
- R12: After reset the queue is empty and all status and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | 16 | Tick divisor; one tick every divisor+1 clocks |
| data_len_i | input | 2 | Data length code |
| two_stop_i | input | 1 | Stop-bit count select |
| parity_i | input | 3 | Parity mode code |
| trig_lvl_i | input | 2 | Interrupt fill level code |
| rx_int_en_i | input | 1 | Fill interrupt enable |
| rd_en_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head entry data |
| rd_err_o | output | 4 | Head entry tags: [0] overrun, [1] parity, [2] framing, [3] break |
| fifo_count_o | output | 4 | Queue fill, modulo 16 |
| fifo_full_o | output | 1 | Queue full |
| data_ready_o | output | 1 | Queue not empty |
| fifo_err_o | output | 1 | A stored entry carries an error |
| rx_int_o | output | 1 | Fill-level interrupt |

## Verification
A bad sampling phase or bit counter shows up as wrong data or a spurious parity or framing tag on the very next character. A lost or duplicated state transition after a break or framing error shows up as extra queue entries within one frame time. Errors in the queue pointers or in the pending-error counter stay hidden until the affected entry reaches the head: they then appear as out-of-order data, a tag on the wrong entry, or fifo_err_o clearing one read too early or too late.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_RECOVER
    } rx_state_t;

    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt >= div_i) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R1: with a nonzero divisor, ticks never come back to back
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && $stable(div_i)) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] data_len_i,
    input  logic       two_stop_i,
    input  logic [2:0] parity_i,
    output logic       push_o,
    output logic [7:0] data_o,
    output logic [2:0] err_o      // {break, framing, parity}
);
    rx_state_t  state, nstate;
    logic [3:0] cnt;
    logic [2:0] bit_idx;
    logic       stop_idx;
    logic [7:0] shreg;
    logic       par_acc, par_bad, frm_acc, any_one;

    logic sample, last_bit, last_stop, frm_now, brk_now, par_fail;
    assign sample    = tick_i && (cnt == 4'd15);
    assign last_bit  = (bit_idx == ({1'b0, data_len_i} + 3'd4));
    assign last_stop = !two_stop_i || stop_idx;
    assign frm_now   = frm_acc || !rx_i;
    assign brk_now   = !(any_one || rx_i);

    always_comb begin
        unique case (parity_i)
            3'd4:    par_fail = (par_acc ^ rx_i) != 1'b1;
            3'd5:    par_fail = (par_acc ^ rx_i) != 1'b0;
            3'd6:    par_fail = !rx_i;
            3'd7:    par_fail = rx_i;
            default: par_fail = 1'b0;
        endcase
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:    if (tick_i && !rx_i) nstate = S_START;
            S_START:   if (tick_i && cnt == 4'd7) nstate = rx_i ? S_IDLE : S_DATA;
            S_DATA:    if (sample && last_bit) nstate = parity_i[2] ? S_PARITY : S_STOP;
            S_PARITY:  if (sample) nstate = S_STOP;
            S_STOP:    if (sample && last_stop) nstate = frm_now ? S_RECOVER : S_IDLE;
            S_RECOVER: if (rx_i) nstate = S_IDLE;
            default:   nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            frm_acc  <= 1'b0;
            any_one  <= 1'b0;
            push_o   <= 1'b0;
            data_o   <= '0;
            err_o    <= '0;
        end else begin
            push_o <= 1'b0;
            if (nstate != state) cnt <= '0;
            else if (tick_i)     cnt <= cnt + 1'b1;
            if (state == S_IDLE) begin
                bit_idx  <= '0;
                stop_idx <= 1'b0;
                par_acc  <= 1'b0;
                par_bad  <= 1'b0;
                frm_acc  <= 1'b0;
                any_one  <= 1'b0;
            end
            if (sample) begin
                unique case (state)
                    S_DATA: begin
                        shreg   <= {rx_i, shreg[7:1]};
                        par_acc <= par_acc ^ rx_i;
                        any_one <= any_one | rx_i;
                        bit_idx <= bit_idx + 1'b1;
                    end
                    S_PARITY: begin
                        par_bad <= par_fail;
                        any_one <= any_one | rx_i;
                    end
                    S_STOP: begin
                        frm_acc  <= frm_now;
                        any_one  <= any_one | rx_i;
                        stop_idx <= 1'b1;
                        if (last_stop) begin
                            push_o <= 1'b1;
                            data_o <= brk_now ? 8'd0 : (shreg >> (2'd3 - data_len_i));
                            err_o  <= brk_now ? 3'b100 : {1'b0, frm_now, par_bad};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a start is entered only from a low line
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && $past(state) == S_IDLE) |-> !$past(rx_i));
    // R5: recovery is entered only together with a damaged character
    a_r5_recover_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECOVER && $past(state) == S_STOP) |-> (push_o && (err_o[2] || err_o[1])));
endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [7:0]                 wdata_i,
    input  logic [2:0]                 werr_i,
    input  logic                       pop_i,
    output logic [7:0]                 rdata_o,
    output logic [3:0]                 rerr_o,
    output logic [$clog2(DEPTH):0]     count_o,
    output logic                       err_pend_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

    logic [7:0]    mem_d [DEPTH];
    logic [3:0]    mem_e [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, last;
    logic [AW:0]   err_cnt;
    logic          full, do_push, do_pop, ovr, err_inc, err_dec;

    assign full    = (count_o == FULLV);
    assign last    = wr_ptr - 1'b1;
    assign do_push = push_i && !full;
    assign ovr     = push_i && full;
    assign do_pop  = pop_i && (count_o != '0);
    assign err_inc = (do_push && (werr_i != '0)) || (ovr && (mem_e[last] == '0));
    assign err_dec = do_pop && (mem_e[rd_ptr] != '0);
    assign rdata_o    = mem_d[rd_ptr];
    assign rerr_o     = mem_e[rd_ptr];
    assign err_pend_o = (err_cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_d[wr_ptr] <= wdata_i;
            mem_e[wr_ptr] <= {werr_i, 1'b0};
        end
        if (ovr) mem_e[last][0] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count_o <= count_o + (AW+1)'(do_push) - (AW+1)'(do_pop);
            err_cnt <= err_cnt + (AW+1)'(err_inc) - (AW+1)'(err_dec);
        end
    end

    // R7: fill never exceeds the depth
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n) count_o <= FULLV);
    // R8: a push into a full queue leaves the fill unchanged
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> count_o == FULLV);
    // R10: a pending error implies a stored entry
    a_r10_err_stored: assert property (@(posedge clk) disable iff (!rst_n)
        err_pend_o |-> count_o != '0);
    // R11: a pop on an empty queue does nothing
    a_r11_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && pop_i && !push_i) |=> count_o == '0);
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rxd_i,
    input  logic [DIV_W-1:0]         baud_div_i,
    input  logic [1:0]               data_len_i,
    input  logic                     two_stop_i,
    input  logic [2:0]               parity_i,
    input  logic [1:0]               trig_lvl_i,
    input  logic                     rx_int_en_i,
    input  logic                     rd_en_i,
    output logic [7:0]               rd_data_o,
    output logic [3:0]               rd_err_o,
    output logic [$clog2(DEPTH)-1:0] fifo_count_o,
    output logic                     fifo_full_o,
    output logic                     data_ready_o,
    output logic                     fifo_err_o,
    output logic                     rx_int_o
);
    localparam int AW = $clog2(DEPTH);

    logic [1:0]  sync;
    logic        tick, push;
    logic [7:0]  fdata;
    logic [2:0]  ferr;
    logic [AW:0] count, thresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd_i};
    end

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick));

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(sync[1]),
        .data_len_i(data_len_i), .two_stop_i(two_stop_i), .parity_i(parity_i),
        .push_o(push), .data_o(fdata), .err_o(ferr));

    uart_rx_efifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(fdata), .werr_i(ferr),
        .pop_i(rd_en_i), .rdata_o(rd_data_o), .rerr_o(rd_err_o),
        .count_o(count), .err_pend_o(fifo_err_o));

    assign thresh       = (AW+1)'((int'(trig_lvl_i) + 1) * (DEPTH / 4));
    assign fifo_count_o = count[AW-1:0];
    assign fifo_full_o  = count[AW];
    assign data_ready_o = (count != '0);
    assign rx_int_o     = rx_int_en_i && (count >= thresh);

    // R9: an interrupt never fires on an empty queue
    a_r9_int_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int_o |-> data_ready_o);
    // R6: a break-tagged head entry carries zero data
    a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready_o && rd_err_o[ERR_BRK]) |-> rd_data_o == 8'd0);
endmodule

// File: tb/test_uart_rx_errfifo.sv
`timescale 1ns/1ps
module test_uart_rx_errfifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] div = 16'd0;
    logic [1:0]  dlen = 2'd3;
    logic        tstop = 1'b0;
    logic [2:0]  pmode = 3'd0;
    logic [1:0]  trig = 2'd0;
    logic        ien = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  rd_err, fcount;
    logic        ffull, dready, ferr, rint;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;

    uart_rx_errfifo i_uart_rx_errfifo (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_div_i(div),
        .data_len_i(dlen), .two_stop_i(tstop), .parity_i(pmode),
        .trig_lvl_i(trig), .rx_int_en_i(ien), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .rd_err_o(rd_err), .fifo_count_o(fcount),
        .fifo_full_o(ffull), .data_ready_o(dready), .fifo_err_o(ferr),
        .rx_int_o(rint));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rxd <= v;
        repeat (16 * (int'(div) + 1)) @(posedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit brk);
        int nb = int'(dlen) + 5;
        logic [7:0] dm = d & 8'((1 << nb) - 1);
        logic pb;
        case (pmode)
            3'd4: pb = ~^dm;
            3'd5: pb = ^dm;
            3'd6: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(brk ? 1'b0 : dm[i]);
        if (pmode[2]) bit_out(brk ? 1'b0 : (pb ^ bad_par));
        bit_out(!(brk || bad_stop));
        if (tstop) bit_out(!(brk || bad_stop));
        bit_out(1'b1);
        bit_out(1'b1);
        @(negedge clk);
    endtask

    task automatic pop;
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(fcount == 0 && !ffull && !dready && !ferr && !rint, "R12 reset", int'(fcount), 0);
        // R11 pop on empty
        pop();
        check(fcount == 0 && !dready, "R11 pop empty", int'(fcount), 0);

        // R2 R4 R5 sweep of all lengths, parity modes and stop counts
        for (int dl = 0; dl < 4; dl++)
            for (int pi = 0; pi < 5; pi++)
                for (int ts = 0; ts < 2; ts++)
                    for (int v = 0; v < 2; v++) begin
                        logic [7:0] d = v ? 8'hA6 ^ 8'(dl * 17) : 8'h5B + 8'(pi * 3);
                        logic [7:0] exp_d;
                        dlen = 2'(dl); tstop = ts[0];
                        pmode = (pi == 0) ? 3'(dl) : 3'(pi + 3);
                        exp_d = d & 8'((1 << (dl + 5)) - 1);
                        send(d, 0, 0, 0);
                        check(dready, "R11 ready", int'(dready), 1);
                        check(rd_data == exp_d, "R2 data", int'(rd_data), int'(exp_d));
                        check(rd_err == 4'b0000, "R4 R5 clean tags", int'(rd_err), 0);
                        pop();
                    end

        // R4 parity mismatch per mode
        dlen = 2'd3; tstop = 1'b0;
        for (int m = 4; m < 8; m++) begin
            pmode = 3'(m);
            send(8'h37, 1, 0, 0);
            check(rd_err == 4'b0010 && rd_data == 8'h37, "R4 parity error", int'(rd_err), 2);
            pop();
        end

        // R5 framing error with one and two stop bits
        pmode = 3'd0;
        for (int ts = 0; ts < 2; ts++) begin
            tstop = ts[0];
            send(8'h81, 0, 1, 0);
            check(rd_err == 4'b0100 && fcount == 1, "R5 framing error", int'(rd_err), 4);
            pop();
        end

        // R6 break
        tstop = 1'b0; pmode = 3'd5;
        send(8'h00, 0, 0, 1);
        check(fcount == 1, "R6 single entry", int'(fcount), 1);
        check(rd_data == 0 && rd_err == 4'b1000, "R6 break tag", int'(rd_err), 8);
        pop();
        check(fcount == 0, "R6 drained", int'(fcount), 0);

        // R3 short low glitch
        pmode = 3'd0;
        rxd <= 1'b0;
        repeat (5) @(posedge clk);
        rxd <= 1'b1;
        repeat (64) @(posedge clk);
        @(negedge clk);
        check(fcount == 0 && !dready, "R3 glitch ignored", int'(fcount), 0);
        send(8'hC3, 0, 0, 0);
        check(rd_data == 8'hC3, "R3 frame after glitch", int'(rd_data), 8'hC3);
        pop();

        // R1 slower divisor
        div = 16'd2;
        send(8'h96, 0, 0, 0);
        check(rd_data == 8'h96 && rd_err == 0, "R1 divisor 2", int'(rd_data), 8'h96);
        pop();
        div = 16'd0;

        // R7 R9 fill sweep with all trigger levels
        ien = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            send(8'(k * 7), 0, 0, 0);
            check(fcount == 4'(k % 16) && ffull == (k == 16), "R7 count", int'(fcount), k % 16);
            for (int t = 0; t < 4; t++) begin
                trig = 2'(t);
                @(negedge clk);
                check(rint == (k >= (t + 1) * 4), "R9 trigger", int'(rint), int'(k >= (t + 1) * 4));
            end
        end
        ien = 1'b0;
        @(negedge clk);
        check(!rint, "R9 disabled", int'(rint), 0);

        // R8 overrun on full queue
        send(8'hEE, 0, 0, 0);
        check(ffull && fcount == 0, "R8 still full", int'(fcount), 0);
        check(ferr, "R10 overrun pending", int'(ferr), 1);
        for (int k = 1; k <= 16; k++) begin
            check(rd_data == 8'(k * 7), "R7 order", int'(rd_data), k * 7);
            check(rd_err == ((k == 16) ? 4'b0001 : 4'b0000), "R8 overrun tag", int'(rd_err), (k == 16) ? 1 : 0);
            if (k == 16) check(ferr, "R10 held", int'(ferr), 1);
            pop();
        end
        check(!ferr && !dready, "R10 cleared", int'(ferr), 0);

        // R10 sticky flag over mixed entries
        pmode = 3'd5;
        send(8'h11, 0, 0, 0);
        send(8'h22, 1, 0, 0);
        send(8'h33, 0, 0, 0);
        send(8'h44, 1, 0, 0);
        for (int k = 0; k < 4; k++) begin
            check(ferr, "R10 pending", int'(ferr), 1);
            pop();
        end
        check(!ferr, "R10 last errored read", int'(ferr), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule